// File: doc/BRIEF.md
# Filtered Page Migration Classifier

This block judges, for one memory page shared by four GPUs, whether the page should move and to which GPU. At the end of every counting period the surrounding logic presents the raw access count each GPU made to the page, the GPU that currently holds the page, the length of the period in cycles and a smoothing weight. The block folds each raw count into a per-GPU filtered count with an exponential moving average, remembers the filtered counts of the previous period, and from these values sorts the page into one of five behaviour classes.

The class determines the decision. A page that one GPU clearly dominates goes to that GPU. A page that is evenly shared moves only when its holder barely uses it. A page touched too rarely to pay back a transfer stays put. A page whose holder is cooling off while another GPU warms up follows the warming GPU. Anything else is left alone. The class, a migrate flag and the target GPU are presented two clock edges after the period strobe.

Top module: `mig_classifier`

## Requirements
- R1: While reset is asserted and after its release, before any period strobe, `res_vld_o`, `cls_o`, `mig_o` and `tgt_o` are all 0, and every filtered count and stored previous count is 0.
- R2: On each period strobe every GPU's filtered count F (unsigned, 8 integer and 8 fraction bits, raw count N taken as an 8-bit integer) becomes floor(((256−a)·F + a·N·256) / 256), where a is `alpha_i` read as a/256.
- R3: The result for a strobe sampled at clock edge k appears on the outputs after edge k+1, with `res_vld_o` high for exactly that one cycle; the previous count of each GPU becomes its filtered count from before the strobe.
- R4: If the highest filtered count is 0 the class is out-of-interest (code 0) and no migration is flagged.
- R5: Streaming (code 3, never migrated) applies when the page had a nonzero raw total in some earlier period and 100·(sum of raw counts) < 3·`plen_i` for the current period; it takes priority over every class except R4.
- R6: Mostly-dedicated (code 1) applies when the highest filtered count is at least 2 times the second highest; the page migrates to the highest GPU unless `loc_i` already equals it.
- R7: Shared (code 2) applies when 10·highest < 13·second highest; the page migrates to the highest GPU only when 4·(count of the holding GPU) < highest.
- R8: Owner-shifting (code 4) applies when neither R6 nor R7 holds, the holding GPU's filtered count is below its previous count and at least one other GPU's count is above its previous count; the target is the lowest-index such rising GPU.
- R9: A page matching none of R4 to R8 is out-of-interest (code 0) and is not migrated; whenever `mig_o` is 0, `tgt_o` is 0.
- R10: When several GPUs share the highest filtered count, the lowest GPU index is the highest one and the second highest equals the same value.
- R11: Without a period strobe the filtered counts do not change, and a strobe with `alpha_i` = 0 leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_i | input | 1 | One-cycle strobe: a new period's counts are present |
| cnt_i | input | 32 | Raw counts, GPU g in bits [8g+7:8g] |
| loc_i | input | 2 | GPU currently holding the page |
| plen_i | input | 16 | Period length in cycles |
| alpha_i | input | 8 | Filter weight as a fraction of 256 |
| res_vld_o | output | 1 | Decision outputs are new this cycle |
| cls_o | output | 3 | Class: 0 none, 1 dedicated, 2 shared, 3 streaming, 4 owner-shifting |
| mig_o | output | 1 | Page should migrate |
| tgt_o | output | 2 | Target GPU when migrating, else 0 |

## Verification
The streaming test and the dedicated test can both be true for the same period, since a page touched once in a long period by one GPU has a dominant filtered count. The bench provokes this by strobing a single access twice after reset with a period of 1000 cycles: the first strobe must give dedicated because the page was never touched before, the second must give streaming with no migration although the dedicated ratio still holds. The shared and owner-shifting tests overlap in the same way when the holding GPU is falling, and the table orders its vectors so that both a falling holder with a rising neighbour and a falling holder without one are judged.

// File: rtl/mig_pkg.sv
package mig_pkg;
  typedef enum logic [2:0] {
    CLS_NONE  = 3'd0,
    CLS_DED   = 3'd1,
    CLS_SHR   = 3'd2,
    CLS_STR   = 3'd3,
    CLS_SHIFT = 3'd4
  } cls_e;

  localparam int DED_RATIO  = 2;
  localparam int SHR_NUM    = 13;
  localparam int SHR_DEN    = 10;
  localparam int LOW_DIV    = 4;
  localparam int STR_NUM    = 3;
  localparam int STR_DEN    = 100;
endpackage

// File: rtl/mig_filter.sv
module mig_filter #(
  parameter int CNT_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int ALPHA_W = 8,
  localparam int FW     = CNT_W + FRAC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_i,
  input  logic [ALPHA_W-1:0] alpha_i,
  input  logic [CNT_W-1:0]   n_i,
  output logic [FW-1:0]      f_o,
  output logic [FW-1:0]      p_o
);
  localparam int AW = FW + ALPHA_W + 1;
  localparam logic [AW-1:0] ONE = AW'(2 ** ALPHA_W);

  logic [FW-1:0] f_q, f_nx, p_q, p_nx, n_fix;
  logic [AW-1:0] acc;

  always_comb begin
    n_fix = {n_i, {FRAC_W{1'b0}}};
    acc   = (ONE - AW'(alpha_i)) * AW'(f_q) + AW'(alpha_i) * AW'(n_fix);
    f_nx  = f_q;
    p_nx  = p_q;
    if (upd_i) begin
      f_nx = acc[ALPHA_W +: FW];
      p_nx = f_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= '0;
      p_q <= '0;
    end else begin
      f_q <= f_nx;
      p_q <= p_nx;
    end
  end

  assign f_o = f_q;
  assign p_o = p_q;

  // R2: the new value lies between the old value and the new sample
  p_filt_bounded_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_i |=> ((f_q <= $past(f_q) || f_q <= $past(n_fix)) &&
               (f_q >= $past(f_q) || f_q >= $past(n_fix))));
  // R11: no strobe, no change
  p_filt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_i |=> $stable(f_q));
endmodule

// File: rtl/mig_rank.sv
module mig_rank #(
  parameter int NGPU = 4,
  parameter int FW   = 16,
  localparam int IW  = $clog2(NGPU)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NGPU-1:0][FW-1:0]  f_i,
  output logic [IW-1:0]            top_idx_o,
  output logic [FW-1:0]            top_o,
  output logic [FW-1:0]            sec_o
);
  always_comb begin
    top_idx_o = '0;
    top_o     = f_i[0];
    for (int g = 1; g < NGPU; g++) begin
      if (f_i[g] > top_o) begin
        top_o     = f_i[g];
        top_idx_o = IW'(g);
      end
    end
    sec_o = '0;
    for (int g = 0; g < NGPU; g++) begin
      if (IW'(g) != top_idx_o && f_i[g] > sec_o) sec_o = f_i[g];
    end
  end

  // R10: the ranking is ordered and the top index holds the top value
  p_rank_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (top_o >= sec_o) && (f_i[top_idx_o] == top_o));
endmodule

// File: rtl/mig_decide.sv
module mig_decide
  import mig_pkg::*;
#(
  parameter int NGPU = 4,
  parameter int FW   = 16,
  localparam int IW  = $clog2(NGPU),
  localparam int WW  = FW + 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     eval_i,
  input  logic                     stream_i,
  input  logic [IW-1:0]            loc_i,
  input  logic [NGPU-1:0][FW-1:0]  f_i,
  input  logic [NGPU-1:0][FW-1:0]  p_i,
  input  logic [IW-1:0]            top_idx_i,
  input  logic [FW-1:0]            top_i,
  input  logic [FW-1:0]            sec_i,
  output logic                     vld_o,
  output logic [2:0]               cls_o,
  output logic                     mig_o,
  output logic [IW-1:0]            tgt_o
);
  cls_e          cls_nx;
  logic          mig_nx, ris, vld_q, mig_q;
  logic [IW-1:0] tgt_nx, ris_idx, tgt_q;
  logic [2:0]    cls_q;
  logic [WW-1:0] top_w, sec_w, loc_w;

  always_comb begin
    top_w = WW'(top_i);
    sec_w = WW'(sec_i);
    loc_w = WW'(f_i[loc_i]);
    ris     = 1'b0;
    ris_idx = '0;
    for (int g = NGPU - 1; g >= 0; g--) begin
      if (IW'(g) != loc_i && f_i[g] > p_i[g]) begin
        ris     = 1'b1;
        ris_idx = IW'(g);
      end
    end
    cls_nx = CLS_NONE;
    mig_nx = 1'b0;
    tgt_nx = '0;
    if (top_i == '0) begin
      cls_nx = CLS_NONE;
    end else if (stream_i) begin
      cls_nx = CLS_STR;
    end else if (top_w >= WW'(DED_RATIO) * sec_w) begin
      cls_nx = CLS_DED;
      mig_nx = (top_idx_i != loc_i);
      tgt_nx = mig_nx ? top_idx_i : '0;
    end else if (WW'(SHR_DEN) * top_w < WW'(SHR_NUM) * sec_w) begin
      cls_nx = CLS_SHR;
      mig_nx = (WW'(LOW_DIV) * loc_w < top_w);
      tgt_nx = mig_nx ? top_idx_i : '0;
    end else if (f_i[loc_i] < p_i[loc_i] && ris) begin
      cls_nx = CLS_SHIFT;
      mig_nx = 1'b1;
      tgt_nx = ris_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      cls_q <= '0;
      mig_q <= 1'b0;
      tgt_q <= '0;
    end else begin
      vld_q <= eval_i;
      if (eval_i) begin
        cls_q <= cls_nx;
        mig_q <= mig_nx;
        tgt_q <= tgt_nx;
      end
    end
  end

  assign vld_o = vld_q;
  assign cls_o = cls_q;
  assign mig_o = mig_q;
  assign tgt_o = tgt_q;

  // R5: streaming and out-of-interest pages never migrate
  p_no_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_q == CLS_STR || cls_q == CLS_NONE) |-> !mig_q);
  // R9: idle target
  p_idle_tgt_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !mig_q |-> (tgt_q == '0));
  // R6: a migration never targets the holder used for the decision
  p_not_self_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_i && mig_nx) |=> (tgt_q != $past(loc_i)));
  // R3: outputs change only on a result cycle
  p_out_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_q |-> ($stable(cls_q) && $stable(mig_q)));
endmodule

// File: rtl/mig_classifier.sv
module mig_classifier
  import mig_pkg::*;
#(
  parameter int NGPU    = 4,
  parameter int CNT_W   = 8,
  parameter int FRAC_W  = 8,
  parameter int ALPHA_W = 8,
  parameter int PLEN_W  = 16,
  localparam int IW     = $clog2(NGPU),
  localparam int FW     = CNT_W + FRAC_W,
  localparam int SUM_W  = CNT_W + IW,
  localparam int RW     = SUM_W + PLEN_W + 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_i,
  input  logic [NGPU*CNT_W-1:0]   cnt_i,
  input  logic [IW-1:0]           loc_i,
  input  logic [PLEN_W-1:0]       plen_i,
  input  logic [ALPHA_W-1:0]      alpha_i,
  output logic                    res_vld_o,
  output logic [2:0]              cls_o,
  output logic                    mig_o,
  output logic [IW-1:0]           tgt_o
);
  logic rs_meta, rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  logic [NGPU-1:0][FW-1:0] filt, prev;

  for (genvar g = 0; g < NGPU; g++) begin : g_filt
    mig_filter #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .ALPHA_W(ALPHA_W)) u_filt (
      .clk     (clk),
      .rst_n   (rs_n),
      .upd_i   (upd_i),
      .alpha_i (alpha_i),
      .n_i     (cnt_i[g*CNT_W +: CNT_W]),
      .f_o     (filt[g]),
      .p_o     (prev[g])
    );
  end

  logic [SUM_W-1:0] sum;
  logic [RW-1:0]    rate_l, rate_r;
  logic             touched_q, touched_nx, stream_q, stream_nx, eval_q;
  logic [IW-1:0]    loc_q, loc_nx;

  always_comb begin
    sum = '0;
    for (int g = 0; g < NGPU; g++) sum = sum + SUM_W'(cnt_i[g*CNT_W +: CNT_W]);
    rate_l     = RW'(STR_DEN) * RW'(sum);
    rate_r     = RW'(STR_NUM) * RW'(plen_i);
    stream_nx  = stream_q;
    touched_nx = touched_q;
    loc_nx     = loc_q;
    if (upd_i) begin
      stream_nx  = touched_q && (rate_l < rate_r);
      touched_nx = touched_q || (sum != '0);
      loc_nx     = loc_i;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      stream_q  <= 1'b0;
      touched_q <= 1'b0;
      loc_q     <= '0;
      eval_q    <= 1'b0;
    end else begin
      stream_q  <= stream_nx;
      touched_q <= touched_nx;
      loc_q     <= loc_nx;
      eval_q    <= upd_i;
    end
  end

  logic [IW-1:0] top_idx;
  logic [FW-1:0] top_v, sec_v;

  mig_rank #(.NGPU(NGPU), .FW(FW)) u_rank (
    .clk       (clk),
    .rst_n     (rs_n),
    .f_i       (filt),
    .top_idx_o (top_idx),
    .top_o     (top_v),
    .sec_o     (sec_v)
  );

  mig_decide #(.NGPU(NGPU), .FW(FW)) u_dec (
    .clk       (clk),
    .rst_n     (rs_n),
    .eval_i    (eval_q),
    .stream_i  (stream_q),
    .loc_i     (loc_q),
    .f_i       (filt),
    .p_i       (prev),
    .top_idx_i (top_idx),
    .top_i     (top_v),
    .sec_i     (sec_v),
    .vld_o     (res_vld_o),
    .cls_o     (cls_o),
    .mig_o     (mig_o),
    .tgt_o     (tgt_o)
  );

  // R3: a strobe yields exactly one result pulse two edges later
  p_vld_pulse_r3: assert property (@(posedge clk) disable iff (!rs_n)
    upd_i |=> ##1 res_vld_o);
  // R3: no result without a strobe
  p_vld_cause_r3: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(res_vld_o) |-> $past(upd_i, 2));
  // R5: the first touched period can never be streaming
  p_first_touch_r5: assert property (@(posedge clk) disable iff (!rs_n)
    (upd_i && !touched_q) |=> !stream_q);
endmodule

// File: tb/mig_classifier_test.sv
module mig_classifier_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_i;
  logic [31:0] cnt_i;
  logic [1:0]  loc_i;
  logic [15:0] plen_i;
  logic [7:0]  alpha_i;
  logic        res_vld_o;
  logic [2:0]  cls_o;
  logic        mig_o;
  logic [1:0]  tgt_o;

  always #2 clk = ~clk;

  mig_classifier uut (
    .clk(clk), .rst_n(rst_n), .upd_i(upd_i), .cnt_i(cnt_i), .loc_i(loc_i),
    .plen_i(plen_i), .alpha_i(alpha_i), .res_vld_o(res_vld_o),
    .cls_o(cls_o), .mig_o(mig_o), .tgt_o(tgt_o)
  );

  typedef struct packed {
    logic [7:0]  c0, c1, c2, c3;
    logic [1:0]  loc;
    logic [15:0] plen;
    logic [7:0]  alpha;
    logic [2:0]  cls;
    logic        mig;
    logic [1:0]  tgt;
  } vec_t;

  // Applied in order from reset; filtered values in comments are Q8.8 words.
  localparam vec_t TBL [9] = '{
    '{8'd100, 8'd0,   8'd0,   8'd0, 2'd1, 16'd1,    8'd128, 3'd1, 1'b1, 2'd0}, // F0=12800 R6
    '{8'd100, 8'd0,   8'd0,   8'd0, 2'd0, 16'd1,    8'd128, 3'd1, 1'b0, 2'd0}, // F0=19200 R6 on owner
    '{8'd0,   8'd200, 8'd0,   8'd0, 2'd0, 16'd1,    8'd128, 3'd1, 1'b1, 2'd1}, // 9600/25600 R6 exact 2x bound area
    '{8'd200, 8'd200, 8'd0,   8'd0, 2'd1, 16'd1,    8'd128, 3'd2, 1'b0, 2'd0}, // 30400/38400 R7 holder is top
    '{8'd200, 8'd200, 8'd0,   8'd0, 2'd3, 16'd1,    8'd128, 3'd2, 1'b1, 2'd1}, // R7 holder very low
    '{8'd0,   8'd150, 8'd200, 8'd0, 2'd0, 16'd1,    8'd128, 3'd4, 1'b1, 2'd2}, // R8 holder falls, GPU2 rises
    '{8'd0,   8'd162, 8'd100, 8'd0, 2'd1, 16'd1,    8'd128, 3'd0, 1'b0, 2'd0}, // R9 falls, none rises
    '{8'd0,   8'd1,   8'd0,   8'd0, 2'd1, 16'd1000, 8'd128, 3'd3, 1'b0, 2'd0}, // R5 streaming
    '{8'd255, 8'd0,   8'd0,   8'd0, 2'd1, 16'd1,    8'd0,   3'd0, 1'b0, 2'd0}  // R11 alpha 0 holds
  };

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    upd_i = 1'b0; cnt_i = '0; loc_i = '0; plen_i = 16'd1; alpha_i = 8'd128;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Strobe at edge k, sample after edge k+1.
  task automatic apply(input logic [7:0] c0, c1, c2, c3, input logic [1:0] loc,
                       input logic [15:0] plen, input logic [7:0] alpha);
    @(negedge clk);
    cnt_i = {c3, c2, c1, c0}; loc_i = loc; plen_i = plen; alpha_i = alpha;
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
    chk("R3 vld low one edge after strobe", int'(res_vld_o), 0);
    @(negedge clk);
  endtask

  task automatic expect_res(input string req, input int cls, input int mig, input int tgt);
    chk({req, " vld"}, int'(res_vld_o), 1);
    chk({req, " cls"}, int'(cls_o), cls);
    chk({req, " mig"}, int'(mig_o), mig);
    chk({req, " tgt"}, int'(tgt_o), tgt);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    upd_i = 1'b0; cnt_i = '0; loc_i = '0; plen_i = 16'd1; alpha_i = 8'd128;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    chk("R1 vld in reset", int'(res_vld_o), 0);
    chk("R1 cls in reset", int'(cls_o), 0);
    chk("R1 mig in reset", int'(mig_o), 0);
    chk("R1 tgt in reset", int'(tgt_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld after release", int'(res_vld_o), 0);

    // R4: all-zero counts give out-of-interest
    apply(8'd0, 8'd0, 8'd0, 8'd0, 2'd2, 16'd1, 8'd128);
    expect_res("R4 zero page", 0, 0, 0);
    @(negedge clk);
    chk("R3 vld single pulse", int'(res_vld_o), 0);

    // R10: tie between GPU1 and GPU2, holder GPU3 very low -> R7 to GPU1
    do_reset();
    apply(8'd0, 8'd80, 8'd80, 8'd0, 2'd3, 16'd1, 8'd128);
    expect_res("R10 tie lowest index", 2, 1, 1);

    // R5: first touch is not streaming (dedicated), second is streaming
    do_reset();
    apply(8'd1, 8'd0, 8'd0, 8'd0, 2'd0, 16'd1000, 8'd128);
    expect_res("R5 first period exempt", 1, 0, 0);
    apply(8'd1, 8'd0, 8'd0, 8'd0, 2'd1, 16'd1000, 8'd128);
    expect_res("R5 streaming beats dedicated", 3, 0, 0);

    // Table walk from a fresh reset: R2 R6 R7 R8 R9 R5 R11
    do_reset();
    for (int i = 0; i < 9; i++) begin
      apply(TBL[i].c0, TBL[i].c1, TBL[i].c2, TBL[i].c3, TBL[i].loc,
            TBL[i].plen, TBL[i].alpha);
      expect_res($sformatf("R2 table vector %0d", i),
                 int'(TBL[i].cls), int'(TBL[i].mig), int'(TBL[i].tgt));
    end

    // R11: outputs hold with no strobe
    repeat (5) @(negedge clk);
    chk("R11 no strobe cls", int'(cls_o), 0);
    chk("R11 no strobe vld", int'(res_vld_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule